// File: doc/BRIEF.md
# Per-Slot Offset and Split-Gain Calibrator

This block corrects raw signed conversion results one word at a time. Each word arrives with the index of the logical slot that produced it. The block looks up that slot's offset and its two gain coefficients, subtracts the offset, and scales the difference. The gain used depends on the sign of the difference: a positive difference uses the positive-side gain and a negative difference uses the negative-side gain. The product is rounded, clipped to a 16-bit range, and presented in either two's-complement or offset-binary coding.

Gains are unsigned 24-bit fixed-point numbers with 23 fractional bits, so 0x800000 is exactly 1.0. After reset every slot has offset zero and both gains at unity, which makes the block a pass-through until software loads real coefficients.

A register-style port loads and reads back the coefficients. The same port reads the last corrected word of each slot, so all active slots can be collected in one burst. Only the first `active_slots` entries can be reached through this port.

Top module: `slot_calibrator`

## Requirements
- R1: A word is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low in any cycle where `cfg_we` is high and high in every other cycle after reset.
- R2: Each accepted word produces exactly one result. `out_valid` is high for one cycle after the third rising edge, counting the accepting edge as the first. `out_slot` carries the slot index of that word.
- R3: The result is built from d = raw − offset, with both values signed 24-bit. d is multiplied by the slot's positive gain when d ≥ 0 and by its negative gain when d < 0.
- R4: Gains are unsigned with 23 fractional bits (0x800000 = 1.0). The scaled value is floor((d·g + 2^22) / 2^23), which rounds to nearest with halves going toward +∞.
- R5: A scaled value above 32767 gives 32767, and one below −32768 gives −32768. Values never wrap.
- R6: With `twos_comp` = 1, `out_data` is the clipped value in two's complement. With `twos_comp` = 0, the same value has bit 15 inverted (offset binary: 0 → 0x8000). `twos_comp` is sampled at the last pipeline stage.
- R7: Reset clears `out_valid` and all stored results, and sets every slot to offset 0 with both gains at 0x800000.
- R8: The config port uses `cfg_sel` values 0 = offset, 1 = positive gain, 2 = negative gain, 3 = result store. A write takes effect on the clock edge only when `cfg_sel` ≠ 3 and `cfg_addr` < `active_slots`; any other write has no effect. The read data is combinational and reads 0 when `cfg_addr` ≥ `active_slots`.
- R9: Every result is also stored under its slot index. A read with `cfg_sel` = 3 returns the newest stored word for that slot, zero-extended to 24 bits. The stored word is readable in the same cycle that `out_valid` shows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Raw word present |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | 24 | Raw signed conversion word |
| in_slot | input | 3 | Logical slot of the raw word |
| twos_comp | input | 1 | 1 = two's-complement output, 0 = offset binary |
| active_slots | input | 4 | Number of active slots (0..8) |
| out_valid | output | 1 | Corrected word valid |
| out_data | output | 16 | Corrected, clipped, coded word |
| out_slot | output | 3 | Slot of the corrected word |
| cfg_we | input | 1 | Config write strobe |
| cfg_sel | input | 2 | Config target: 0 offset, 1 pos gain, 2 neg gain, 3 results |
| cfg_addr | input | 3 | Slot index for config access |
| cfg_wdata | input | 24 | Config write data |
| cfg_rdata | output | 24 | Config read data |

## Verification
Unity coefficients after reset, with small raw values, show whether the offset and gain path really bypasses the data. Raw values far beyond 16 bits in both directions separate correct clipping from wrap-around. Gain pairs such as 1.5/1.5 and nearly-2.0/0.5 applied to ±1 and ±100 show two things: whether halves round upward, and whether the gain is chosen by the sign of the difference rather than the sign of the raw word. Long random runs mix random coefficients and offsets, interleaved config writes that stall the input, and a switch of output coding. Config writes outside the active range are followed by readbacks, which show that those writes leave nothing behind.

// File: rtl/slot_calibrator.sv
module slot_calibrator #(
  parameter int SLOTS  = 8,
  parameter int COEF_W = 24,
  parameter int OUT_W  = 16,
  parameter int FRAC   = 23
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [COEF_W-1:0]          in_data,
  input  logic [$clog2(SLOTS)-1:0]   in_slot,
  input  logic                       twos_comp,
  input  logic [$clog2(SLOTS):0]     active_slots,
  output logic                       out_valid,
  output logic [OUT_W-1:0]           out_data,
  output logic [$clog2(SLOTS)-1:0]   out_slot,
  input  logic                       cfg_we,
  input  logic [1:0]                 cfg_sel,
  input  logic [$clog2(SLOTS)-1:0]   cfg_addr,
  input  logic [COEF_W-1:0]          cfg_wdata,
  output logic [COEF_W-1:0]          cfg_rdata
);
  localparam int SW     = $clog2(SLOTS);
  localparam int DIFF_W = COEF_W + 1;
  localparam int PROD_W = DIFF_W + COEF_W + 1;
  localparam logic [COEF_W-1:0] UNITY = COEF_W'(1) << FRAC;
  localparam logic signed [PROD_W-1:0] HALF   = PROD_W'(1) << (FRAC - 1);
  localparam logic signed [PROD_W-1:0] SAT_HI = (PROD_W'(1) << (OUT_W - 1)) - PROD_W'(1);
  localparam logic signed [PROD_W-1:0] SAT_LO = ~SAT_HI;

  logic [COEF_W-1:0] off_mem [SLOTS];
  logic [COEF_W-1:0] gp_mem  [SLOTS];
  logic [COEF_W-1:0] gn_mem  [SLOTS];
  logic [OUT_W-1:0]  res_mem [SLOTS];

  logic addr_ok;
  assign addr_ok  = {1'b0, cfg_addr} < active_slots;
  assign in_ready = !cfg_we;

  always_comb begin
    cfg_rdata = '0;
    if (addr_ok) begin
      case (cfg_sel)
        2'd0: cfg_rdata = off_mem[cfg_addr];
        2'd1: cfg_rdata = gp_mem[cfg_addr];
        2'd2: cfg_rdata = gn_mem[cfg_addr];
        default: cfg_rdata = {{(COEF_W-OUT_W){1'b0}}, res_mem[cfg_addr]};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        off_mem[i] <= '0;
        gp_mem[i]  <= UNITY;
        gn_mem[i]  <= UNITY;
      end
    end else if (cfg_we && addr_ok) begin
      case (cfg_sel)
        2'd0: off_mem[cfg_addr] <= cfg_wdata;
        2'd1: gp_mem[cfg_addr]  <= cfg_wdata;
        2'd2: gn_mem[cfg_addr]  <= cfg_wdata;
        default: ;
      endcase
    end
  end

  // stage 1: offset subtract and gain pick
  logic signed [DIFF_W-1:0] diff;
  assign diff = DIFF_W'($signed(in_data)) - DIFF_W'($signed(off_mem[in_slot]));

  logic                      s1_v, s2_v;
  logic [SW-1:0]             s1_slot, s2_slot;
  logic signed [DIFF_W-1:0]  s1_diff;
  logic [COEF_W-1:0]         s1_gain;
  logic signed [PROD_W-1:0]  s2_prod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_slot <= '0; s1_diff <= '0; s1_gain <= '0;
    end else begin
      s1_v <= in_valid && in_ready;
      if (in_valid && in_ready) begin
        s1_slot <= in_slot;
        s1_diff <= diff;
        s1_gain <= diff[DIFF_W-1] ? gn_mem[in_slot] : gp_mem[in_slot];
      end
    end
  end

  // stage 2: multiply
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v <= 1'b0; s2_slot <= '0; s2_prod <= '0;
    end else begin
      s2_v <= s1_v;
      if (s1_v) begin
        s2_slot <= s1_slot;
        s2_prod <= PROD_W'(s1_diff) * $signed({1'b0, s1_gain});
      end
    end
  end

  // stage 3: round, clip, code
  logic signed [PROD_W-1:0] rnd, clip;
  logic [OUT_W-1:0] coded;
  assign rnd   = (s2_prod + HALF) >>> FRAC;
  assign clip  = (rnd > SAT_HI) ? SAT_HI : (rnd < SAT_LO) ? SAT_LO : rnd;
  assign coded = twos_comp ? clip[OUT_W-1:0] : {~clip[OUT_W-1], clip[OUT_W-2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_data <= '0; out_slot <= '0;
      for (int i = 0; i < SLOTS; i++) res_mem[i] <= '0;
    end else begin
      out_valid <= s2_v;
      if (s2_v) begin
        out_data <= coded;
        out_slot <= s2_slot;
        res_mem[s2_slot] <= coded;
      end
    end
  end
endmodule

module slot_calibrator_chk #(
  parameter int SLOTS  = 8,
  parameter int COEF_W = 24,
  parameter int OUT_W  = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic [$clog2(SLOTS)-1:0]   in_slot,
  input logic [$clog2(SLOTS):0]     active_slots,
  input logic                       out_valid,
  input logic [OUT_W-1:0]           out_data,
  input logic [$clog2(SLOTS)-1:0]   out_slot,
  input logic                       cfg_we,
  input logic [1:0]                 cfg_sel,
  input logic [$clog2(SLOTS)-1:0]   cfg_addr,
  input logic [COEF_W-1:0]          cfg_wdata,
  input logic [COEF_W-1:0]          cfg_rdata
);
  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid && in_ready, 3));
  // R2
  slot_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_slot == $past(in_slot, 3));
  // R8
  coef_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel != 2'd3 && {1'b0, cfg_addr} < active_slots) ##1
    (!cfg_we && $stable(cfg_sel) && $stable(cfg_addr) && $stable(active_slots))
    |-> cfg_rdata == $past(cfg_wdata));
  // R9
  result_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_sel == 2'd3 && cfg_addr == out_slot && {1'b0, cfg_addr} < active_slots)
    |-> cfg_rdata == {{(COEF_W-OUT_W){1'b0}}, out_data});
  // R1
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> $past(!cfg_we));
endmodule

bind slot_calibrator slot_calibrator_chk #(.SLOTS(SLOTS), .COEF_W(COEF_W), .OUT_W(OUT_W)) u_chk (.*);

// File: tb/slot_calibrator_tb.sv
`timescale 1ns/1ps
module slot_calibrator_tb;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready;
  logic [23:0] in_data = 0;
  logic [2:0] in_slot = 0;
  logic twos_comp = 1;
  logic [3:0] active_slots = 4'd8;
  logic out_valid;
  logic [15:0] out_data;
  logic [2:0] out_slot;
  logic cfg_we = 0;
  logic [1:0] cfg_sel = 0;
  logic [2:0] cfg_addr = 0;
  logic [23:0] cfg_wdata = 0, cfg_rdata;

  int checks = 0, errors = 0;

  slot_calibrator u_dut (.*);

  always #10 clk = ~clk;

  logic [23:0] off_m [8], gp_m [8], gn_m [8];
  logic [15:0] res_m [8];
  bit ev [3];
  logic [15:0] ed [3];
  logic [2:0] es [3];

  function automatic logic [15:0] model(logic [23:0] raw, logic [23:0] off,
                                        logic [23:0] gp, logic [23:0] gn, bit tc);
    longint d, g, r;
    logic [15:0] v;
    d = longint'($signed(raw)) - longint'($signed(off));
    g = (d < 0) ? longint'(gn) : longint'(gp);
    r = (d * g + 64'sd4194304) >>> 23;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    v = r[15:0];
    return tc ? v : (v ^ 16'h8000);
  endfunction

  function automatic logic [23:0] rd_model(logic [1:0] sel, logic [2:0] a);
    if ({1'b0, a} >= active_slots) return 24'h0;
    case (sel)
      2'd0: return off_m[a];
      2'd1: return gp_m[a];
      2'd2: return gn_m[a];
      default: return {8'h0, res_m[a]};
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(bit v, logic [23:0] d, logic [2:0] s, bit we,
                      logic [1:0] sel, logic [2:0] a, logic [23:0] wd,
                      bit rd, string req);
    @(negedge clk);
    check(out_valid == ev[2], "R2 valid", {23'h0, out_valid}, {23'h0, ev[2]});
    if (ev[2]) begin
      check(out_slot == es[2], "R2 slot", {21'h0, out_slot}, {21'h0, es[2]});
      check(out_data == ed[2], req, {8'h0, out_data}, {8'h0, ed[2]});
      res_m[es[2]] = ed[2];
    end
    in_valid = v; in_data = d; in_slot = s;
    cfg_we = we; cfg_sel = sel; cfg_addr = a; cfg_wdata = wd;
    ev[2] = ev[1]; ed[2] = ed[1]; es[2] = es[1];
    ev[1] = ev[0]; ed[1] = ed[0]; es[1] = es[0];
    ev[0] = v && !we;
    if (ev[0]) begin
      ed[0] = model(d, off_m[s], gp_m[s], gn_m[s], twos_comp);
      es[0] = s;
    end
    if (we && sel != 2'd3 && {1'b0, a} < active_slots) begin
      if (sel == 2'd0) off_m[a] = wd;
      else if (sel == 2'd1) gp_m[a] = wd;
      else gn_m[a] = wd;
    end
    #1;
    if (v) check(in_ready == !we, "R1 ready", {23'h0, in_ready}, {23'h0, !we});
    if (rd) check(cfg_rdata == rd_model(sel, a), req, cfg_rdata, rd_model(sel, a));
  endtask

  task automatic push(logic [23:0] d, logic [2:0] s, string req);
    step(1, d, s, 0, 0, 0, 0, 0, req);
  endtask
  task automatic wr(logic [1:0] sel, logic [2:0] a, logic [23:0] wd);
    step(0, 0, 0, 1, sel, a, wd, 0, "R8");
  endtask
  task automatic rd(logic [1:0] sel, logic [2:0] a, string req);
    step(0, 0, 0, 0, sel, a, 0, 1, req);
  endtask
  task automatic drain();
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "R2");
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) begin
      off_m[i] = 0; gp_m[i] = 24'h800000; gn_m[i] = 24'h800000; res_m[i] = 0;
    end
    for (int i = 0; i < 3; i++) begin ev[i] = 0; ed[i] = 0; es[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R7 reset state
    check(out_valid == 0, "R7 valid", {23'h0, out_valid}, 24'h0);
    rd(1, 3, "R7 pos gain");
    rd(2, 6, "R7 neg gain");
    rd(0, 2, "R7 offset");
    rd(3, 5, "R7 result");
    // R4 bypass with unity coefficients
    push(24'd1234, 0, "R4 bypass");
    push(-24'sd777, 1, "R4 bypass neg");
    drain();
    rd(3, 0, "R9 store");
    rd(3, 1, "R9 store");
    // R5 saturation
    push(24'd40000, 2, "R5 hi");
    push(-24'sd40000, 3, "R5 lo");
    push(24'h7FFFFF, 4, "R5 max");
    drain();
    // R6 offset binary
    twos_comp = 0;
    push(24'd0, 0, "R6 zero");
    push(-24'sd1, 1, "R6 neg");
    push(24'd50000, 2, "R6 sat");
    drain();
    twos_comp = 1;
    // R4 rounding: gain 1.5 both sides
    wr(1, 5, 24'hC00000); wr(2, 5, 24'hC00000);
    push(24'd1, 5, "R4 round up");
    push(-24'sd1, 5, "R4 round half");
    drain();
    // R3 sign-chosen gain, offset moves the sign
    wr(1, 6, 24'hFFFFFF); wr(2, 6, 24'h400000);
    push(24'd100, 6, "R3 pos gain");
    push(-24'sd100, 6, "R3 neg gain");
    wr(0, 6, 24'd150);
    push(24'd100, 6, "R3 offset sign");
    drain();
    rd(0, 6, "R8 readback");
    // R8 writes outside active range ignored
    active_slots = 4'd2;
    wr(0, 5, 24'h123456);
    wr(3, 1, 24'h00ABCD);
    rd(0, 5, "R8 out of range");
    rd(3, 1, "R8 result not writable");
    active_slots = 4'd8;
    rd(0, 5, "R8 ignored write");
    rd(1, 5, "R8 kept gain");
    // R1 write collides with input: stalls
    step(1, 24'd55, 3, 1, 2, 3, 24'h900000, 0, "R1 stall");
    push(24'd55, 3, "R1 retry");
    drain();
    // random coefficients
    for (int i = 0; i < 8; i++) begin
      wr(0, i[2:0], 24'($signed($urandom_range(4000)) - 2000));
      wr(1, i[2:0], 24'($urandom_range(24'hFFFFFF, 24'h400000)));
      wr(2, i[2:0], 24'($urandom_range(24'hFFFFFF, 24'h400000)));
    end
    for (int n = 0; n < 600; n++) begin
      bit v, we;
      logic [23:0] d;
      if (n == 300) begin drain(); twos_comp = 0; end
      v = ($urandom_range(9) < 8);
      we = ($urandom_range(9) == 0);
      d = ($urandom_range(9) == 0) ? 24'($urandom) : 24'($signed($urandom_range(100000)) - 50000);
      step(v, d, 3'($urandom_range(7)), we, 2'($urandom_range(2)), 3'($urandom_range(7)),
           24'($urandom_range(24'hFFFFFF, 24'h400000)), 0, "R3 random");
    end
    drain();
    for (int i = 0; i < 8; i++) rd(3, i[2:0], "R9 burst");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule